// File: doc/BRIEF.md
# DDR Write Burst Capture Unit

This block sits on the memory side of a double-data-rate interface and turns a WRITE command plus the data burst that follows it into a stream of beat pairs. On a rising clock edge it decodes the active-low command strobes. When they form a WRITE, it takes the row address, the bank, a two-bit mask, the selected burst size and the selected write latency, all in that one cycle, and places them in a small pending queue.

When the latency has elapsed, the unit captures data on the rising edge and on the falling edge for as many beats as the burst size calls for. The two captured values are merged in the rising-edge domain into one pair per cycle. Each pair leaves tagged with its bank, its address, the index of its first beat, a per-beat masked flag and a last-pair flag.

The decoder stays receptive on every cycle, also while a burst is being captured. Writes may therefore be spaced closely, and a READ or any other command may follow immediately. Those other commands leave the output untouched.

Top module: `wburst_capture`

## Requirements
- R1: A WRITE is decoded on a rising edge when csN, asN and weN are low and refN is high. The addr, bank, dm, burstSel and wrLat values present on that edge belong to that write, and outAddr/outBank carry its addr and bank on every pair of its burst.
- R2: Each pair joins two captures: outRise is the dq value on the rising edge that starts the pair, and outFall is the dq value on the falling edge that follows it.
- R3: The latency is WL = wrLat + 1, giving 1 to 8 cycles. For a write decoded on edge C, pair k is captured from edge C+WL+k and is presented, with outValid high, from edge C+WL+k+1 until the next edge.
- R4: burstSel selects 2 beats (0), 4 beats (1) or 8 beats (2 or 3). The pairs of one burst come out on consecutive cycles with outBeat = 0, 2, 4, 6 (the index of the rising beat), and outLast is high on the final pair only.
- R5: Beat b of a burst of BL beats is flagged as masked when b < BL/2 and dm[0] was high, or when b >= BL/2 and dm[1] was high. outMask[0] flags the rising beat and outMask[1] the falling beat. Masked beats are still delivered.
- R6: A command with csN high, a READ (weN high), or a refresh (refN low) produces no output and does not disturb any burst in flight or pending.
- R7: A new command may be presented on every cycle, including during a burst. Writes whose bursts do not overlap are delivered in issue order, with up to QDEPTH writes pending at once.
- R8: While rstN is low, outValid is low, and writes that were pending or in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; data is captured on both of its edges |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| asN | input | 1 | Address strobe, active low |
| weN | input | 1 | Write enable, active low |
| refN | input | 1 | Refresh strobe, active low |
| addr | input | 21 | Row address, taken with the command |
| bank | input | 3 | Bank address, taken with the command |
| dm | input | 2 | Mask for the first half (bit 0) and the second half (bit 1) of the burst |
| burstSel | input | 2 | Burst size select: 0 selects 2 beats, 1 selects 4, 2 or 3 selects 8 |
| wrLat | input | 3 | Write latency minus one |
| dq | input | 16 | Write data, sampled on both edges |
| outValid | output | 1 | A pair is presented this cycle |
| outAddr | output | 21 | Address of the write the pair belongs to |
| outBank | output | 3 | Bank of the write the pair belongs to |
| outBeat | output | 3 | Index of the pair's rising beat |
| outRise | output | 16 | Rising-edge beat of the pair |
| outFall | output | 16 | Falling-edge beat of the pair |
| outMask | output | 2 | Masked flag for the rising beat (bit 0) and the falling beat (bit 1) |
| outLast | output | 1 | Final pair of the burst |

## Verification
The bench starts with isolated writes at the smallest and the largest latency, paired with each burst size and each mask pattern. These show whether the latency count and the half-burst mask split are right. Two writes placed so that their bursts run seamlessly together, followed at once by a READ, a refresh and a deselected write, show whether the decoder stays receptive and whether non-write commands leak into the output. A reset in the middle of a pending write shows that queued work is discarded. A long random mix of writes with random latency, size and mask, interleaved with the other commands, is then compared pair by pair against a scheduled expectation table, which exposes any ordering or off-by-one timing fault in the pending queue.

// File: rtl/wburst_pkg.sv
package wburst_pkg;
  parameter int ADDR_W = 21;
  parameter int BANK_W = 3;
  parameter int MAX_WL = 8;
  parameter int MAX_BL = 8;

  localparam int WL_W   = $clog2(MAX_WL);
  localparam int DUE_W  = WL_W + 2;
  localparam int PAIR_W = $clog2(MAX_BL / 2);
  localparam int BEAT_W = $clog2(MAX_BL);

  // one write waiting for its latency to run out
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] bank;
    logic [1:0]        dm;
    logic [PAIR_W-1:0] lastPair;
    logic [DUE_W-1:0]  due;
  } pend_t;

  // control to datapath: capture the current pair and tag it
  typedef struct packed {
    logic              take;
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] bank;
    logic [BEAT_W-1:0] beat;
    logic [1:0]        mask;
    logic              last;
  } strobe_t;

  // burst select to index of the final pair
  function automatic logic [PAIR_W-1:0] lastPairOf(input logic [1:0] sel);
    case (sel)
      2'd0:    return PAIR_W'(0);
      2'd1:    return PAIR_W'(1);
      default: return PAIR_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/wburst_cmdq.sv
module wburst_cmdq
  import wburst_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  push,
  input  pend_t pushData,
  input  logic  pop,
  output pend_t head,
  output logic  notEmpty,
  output logic  full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  pend_t             slots [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fill;
  logic              doPop, doPush;

  assign notEmpty = (fill != '0);
  assign full     = (fill == CNT_W'(DEPTH));
  assign doPop    = pop && notEmpty;
  assign doPush   = push && (!full || doPop);
  assign head     = slots[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) slots[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/wburst_ctrl.sv
module wburst_ctrl
  import wburst_pkg::*;
#(
  parameter int QDEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              asN,
  input  logic              weN,
  input  logic              refN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  input  logic [1:0]        dm,
  input  logic [1:0]        burstSel,
  input  logic [WL_W-1:0]   wrLat,
  output strobe_t           stb
);
  logic              isWrite;
  logic [DUE_W-1:0]  tick;
  pend_t             newEntry, head;
  logic              notEmpty, full, headDue;

  logic              actOn;
  logic [PAIR_W-1:0] actPair, actLastPair;
  logic [ADDR_W-1:0] actAddr;
  logic [BANK_W-1:0] actBank;
  logic [1:0]        actDm;

  logic [BEAT_W-1:0] riseBeat, fallBeat, halfBeats;

  // command decode on the rising edge
  assign isWrite = !csN && !asN && !weN && refN;

  always_comb begin
    newEntry.addr     = addr;
    newEntry.bank     = bank;
    newEntry.dm       = dm;
    newEntry.lastPair = lastPairOf(burstSel);
    newEntry.due      = tick + DUE_W'(wrLat) + 1'b1;
  end

  assign headDue = notEmpty && (head.due == tick);

  wburst_cmdq #(.DEPTH(QDEPTH)) u_cmdq (
    .clk     (clk),
    .rstN    (rstN),
    .push    (isWrite),
    .pushData(newEntry),
    .pop     (headDue),
    .head    (head),
    .notEmpty(notEmpty),
    .full    (full)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tick        <= '0;
      actOn       <= 1'b0;
      actPair     <= '0;
      actLastPair <= '0;
      actAddr     <= '0;
      actBank     <= '0;
      actDm       <= '0;
    end else begin
      tick <= tick + 1'b1;
      if (headDue) begin
        actOn       <= 1'b1;
        actPair     <= '0;
        actLastPair <= head.lastPair;
        actAddr     <= head.addr;
        actBank     <= head.bank;
        actDm       <= head.dm;
      end else if (actOn) begin
        if (actPair == actLastPair) actOn   <= 1'b0;
        else                        actPair <= actPair + 1'b1;
      end
    end
  end

  // beat indices of the pair now in the capture registers
  assign riseBeat  = {actPair, 1'b0};
  assign fallBeat  = {actPair, 1'b1};
  assign halfBeats = BEAT_W'(actLastPair) + 1'b1;

  always_comb begin
    stb.take    = actOn;
    stb.addr    = actAddr;
    stb.bank    = actBank;
    stb.beat    = riseBeat;
    stb.mask[0] = (riseBeat < halfBeats) ? actDm[0] : actDm[1];
    stb.mask[1] = (fallBeat < halfBeats) ? actDm[0] : actDm[1];
    stb.last    = (actPair == actLastPair);
  end
endmodule

// File: rtl/wburst_dpath.sv
module wburst_dpath
  import wburst_pkg::*;
#(
  parameter int DQ_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DQ_W-1:0]   dq,
  input  strobe_t           stb,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [BANK_W-1:0] outBank,
  output logic [BEAT_W-1:0] outBeat,
  output logic [DQ_W-1:0]   outRise,
  output logic [DQ_W-1:0]   outFall,
  output logic [1:0]        outMask,
  output logic              outLast
);
  logic [DQ_W-1:0] riseReg, fallReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) riseReg <= '0;
    else       riseReg <= dq;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallReg <= '0;
    else       fallReg <= dq;
  end

  // merge both edges into one pair in the rising-edge domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outAddr  <= '0;
      outBank  <= '0;
      outBeat  <= '0;
      outRise  <= '0;
      outFall  <= '0;
      outMask  <= '0;
      outLast  <= 1'b0;
    end else begin
      outValid <= stb.take;
      if (stb.take) begin
        outAddr <= stb.addr;
        outBank <= stb.bank;
        outBeat <= stb.beat;
        outRise <= riseReg;
        outFall <= fallReg;
        outMask <= stb.mask;
        outLast <= stb.last;
      end
    end
  end
endmodule

// File: rtl/wburst_capture.sv
module wburst_capture
  import wburst_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int QDEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              asN,
  input  logic              weN,
  input  logic              refN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  input  logic [1:0]        dm,
  input  logic [1:0]        burstSel,
  input  logic [WL_W-1:0]   wrLat,
  input  logic [DQ_W-1:0]   dq,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [BANK_W-1:0] outBank,
  output logic [BEAT_W-1:0] outBeat,
  output logic [DQ_W-1:0]   outRise,
  output logic [DQ_W-1:0]   outFall,
  output logic [1:0]        outMask,
  output logic              outLast
);
  strobe_t stb;

  wburst_ctrl #(.QDEPTH(QDEPTH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .asN     (asN),
    .weN     (weN),
    .refN    (refN),
    .addr    (addr),
    .bank    (bank),
    .dm      (dm),
    .burstSel(burstSel),
    .wrLat   (wrLat),
    .stb     (stb)
  );

  wburst_dpath #(.DQ_W(DQ_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .dq      (dq),
    .stb     (stb),
    .outValid(outValid),
    .outAddr (outAddr),
    .outBank (outBank),
    .outBeat (outBeat),
    .outRise (outRise),
    .outFall (outFall),
    .outMask (outMask),
    .outLast (outLast)
  );
endmodule

// File: rtl/wburst_capture_chk.sv
module wburst_capture_chk
  import wburst_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              outValid,
  input logic [ADDR_W-1:0] outAddr,
  input logic [BANK_W-1:0] outBank,
  input logic [BEAT_W-1:0] outBeat,
  input logic [1:0]        outMask,
  input logic              outLast
);
  // pairs of one burst follow each other with the same tag
  p_contig_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outLast |=> outValid && (outBeat == BEAT_W'($past(outBeat) + 2'd2))
                             && $stable(outAddr) && $stable(outBank));

  // a pair always starts on an even beat
  p_even_beat_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !outBeat[0]);

  // the final pair sits where a 2, 4 or 8 beat burst ends
  p_last_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outLast |-> (outBeat == 3'd0) || (outBeat == 3'd2) || (outBeat == 3'd6));

  // outside the 2-beat case both beats of a pair lie in one half
  p_mask_half_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && (!outLast || outBeat != 3'd0) |-> (outMask[0] == outMask[1]));

  // nothing leaves while reset is held
  p_reset_idle_r8: assert property (@(posedge clk)
    !rstN |-> !outValid);
endmodule

bind wburst_capture wburst_capture_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .outValid(outValid),
  .outAddr (outAddr),
  .outBank (outBank),
  .outBeat (outBeat),
  .outMask (outMask),
  .outLast (outLast)
);

// File: tb/wburst_capture_tb.sv
module wburst_capture_tb;
  localparam int DQ_W = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic        csN, asN, weN, refN;
  logic [20:0] addr;
  logic [2:0]  bank;
  logic [1:0]  dm, burstSel;
  logic [2:0]  wrLat;
  logic [DQ_W-1:0] dq;
  logic        outValid, outLast;
  logic [20:0] outAddr;
  logic [2:0]  outBank, outBeat;
  logic [DQ_W-1:0] outRise, outFall;
  logic [1:0]  outMask;

  always #2 clk = ~clk; // 250 MHz

  wburst_capture u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .asN(asN), .weN(weN), .refN(refN),
    .addr(addr), .bank(bank), .dm(dm), .burstSel(burstSel), .wrLat(wrLat),
    .dq(dq), .outValid(outValid), .outAddr(outAddr), .outBank(outBank),
    .outBeat(outBeat), .outRise(outRise), .outFall(outFall),
    .outMask(outMask), .outLast(outLast)
  );

  typedef struct {
    bit        v;
    bit [20:0] a;
    bit [2:0]  b;
    bit [2:0]  beat;
    bit [15:0] r;
    bit [15:0] f;
    bit [1:0]  m;
    bit        last;
  } exp_t;

  exp_t        expTab [64];
  logic [15:0] riseAt [64];
  logic [15:0] fallAt [64];
  int vectors = 0, errors = 0, edgeN = 0, lastEnd = -100;
  bit inReset = 1'b1, done = 1'b0;

  task automatic cmp(string req, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearTables();
    for (int i = 0; i < 64; i++) begin
      expTab[i].v = 1'b0;
      riseAt[i] = 16'($urandom);
      fallAt[i] = 16'($urandom);
    end
    lastEnd = -100;
  endtask

  task automatic setNop();
    csN = 1'b1; asN = 1'b1; weN = 1'b1; refN = 1'b1;
  endtask

  // compare the pair registered on the edge just passed
  task automatic checkNow();
    int s = edgeN % 64;
    if (inReset) cmp("R8", "outValid in reset", outValid, 0);
    else if (expTab[s].v) begin
      cmp("R3 R7", "outValid", outValid, 1);
      if (outValid) begin
        cmp("R1", "outAddr", outAddr, expTab[s].a);
        cmp("R1", "outBank", outBank, expTab[s].b);
        cmp("R2", "outRise", outRise, expTab[s].r);
        cmp("R2", "outFall", outFall, expTab[s].f);
        cmp("R4", "outBeat", outBeat, expTab[s].beat);
        cmp("R4", "outLast", outLast, expTab[s].last);
        cmp("R5", "outMask", outMask, expTab[s].m);
      end
    end else cmp("R6", "outValid idle", outValid, 0);
    expTab[s].v = 1'b0;
  endtask

  task automatic cycle();
    @(posedge clk);
    edgeN++;
    #1;
    checkNow();
    setNop();
    dq = fallAt[edgeN % 64];
    fallAt[edgeN % 64] = 16'($urandom);
    #2;
    dq = riseAt[(edgeN + 1) % 64];
    riseAt[(edgeN + 1) % 64] = 16'($urandom);
  endtask

  function automatic bit canWrite(int lat);
    return (edgeN + 1 + lat + 1) > lastEnd;
  endfunction

  // drive a WRITE for the next edge and schedule its data and expectations
  task automatic issueWrite(bit [20:0] a, bit [2:0] b, bit [1:0] m, bit [1:0] sel, bit [2:0] lat);
    int c = edgeN + 1;
    int wl = int'(lat) + 1;
    int bl = (sel == 2'd0) ? 2 : (sel == 2'd1) ? 4 : 8;
    csN = 1'b0; asN = 1'b0; weN = 1'b0; refN = 1'b1;
    addr = a; bank = b; dm = m; burstSel = sel; wrLat = lat;
    for (int k = 0; k < bl / 2; k++) begin
      int e = c + wl + k;
      bit [15:0] rv = 16'($urandom);
      bit [15:0] fv = 16'($urandom);
      riseAt[e % 64] = rv;
      fallAt[e % 64] = fv;
      expTab[(e + 1) % 64].v    = 1'b1;
      expTab[(e + 1) % 64].a    = a;
      expTab[(e + 1) % 64].b    = b;
      expTab[(e + 1) % 64].beat = 3'(2 * k);
      expTab[(e + 1) % 64].r    = rv;
      expTab[(e + 1) % 64].f    = fv;
      expTab[(e + 1) % 64].m[0] = (2 * k < bl / 2) ? m[0] : m[1];
      expTab[(e + 1) % 64].m[1] = (2 * k + 1 < bl / 2) ? m[0] : m[1];
      expTab[(e + 1) % 64].last = (k == bl / 2 - 1);
    end
    lastEnd = c + wl + bl / 2 - 1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; setNop();
    addr = '0; bank = '0; dm = '0; burstSel = '0; wrLat = '0; dq = '0;
    clearTables();
    idle(4);                          // R8 reset state
    rstN = 1'b1; inReset = 1'b0;
    idle(2);

    // R3 shortest latency, 2 beats, first-half mask
    issueWrite(21'h1ABCD, 3'd5, 2'b01, 2'd0, 3'd0); cycle();
    idle(6);
    // R3 longest latency, 8 beats, second-half mask
    issueWrite(21'h0F00F, 3'd2, 2'b10, 2'd2, 3'd7); cycle();
    idle(14);
    // R6 non-write commands right behind a write
    issueWrite(21'h12345, 3'd7, 2'b11, 2'd1, 3'd3); cycle();
    csN = 1'b0; asN = 1'b0; weN = 1'b1; refN = 1'b1; cycle();           // READ
    csN = 1'b0; asN = 1'b0; weN = 1'b0; refN = 1'b0; cycle();           // refresh
    csN = 1'b1; asN = 1'b0; weN = 1'b0; refN = 1'b1; addr = 21'h7; cycle(); // deselected
    idle(10);
    // R7 seamless back-to-back bursts, then READ
    issueWrite(21'h00111, 3'd1, 2'b00, 2'd0, 3'd2); cycle();
    issueWrite(21'h00222, 3'd3, 2'b10, 2'd3, 3'd2); cycle();
    csN = 1'b0; asN = 1'b0; weN = 1'b1; refN = 1'b1; cycle();
    idle(12);
    // R8 reset while a write is pending
    issueWrite(21'h0AAAA, 3'd4, 2'b01, 2'd1, 3'd4); cycle();
    idle(2);
    rstN = 1'b0; inReset = 1'b1; clearTables();
    idle(2);
    rstN = 1'b1; inReset = 1'b0;
    idle(12);

    // random mix of commands
    for (int i = 0; i < 3000; i++) begin
      int op = int'($urandom % 8);
      bit [2:0] lat = 3'($urandom);
      if (op < 3 && canWrite(int'(lat)))
        issueWrite(21'($urandom), 3'($urandom), 2'($urandom), 2'($urandom), lat);
      else if (op == 3) begin csN = 1'b0; asN = 1'b0; weN = 1'b1; refN = 1'b1; end
      else if (op == 4) begin csN = 1'b0; asN = 1'($urandom); weN = 1'($urandom); refN = 1'b0; end
      else if (op == 5) begin csN = 1'b1; asN = 1'b0; weN = 1'b0; refN = 1'b1; end
      cycle();
    end
    idle(20);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule